// File: doc/BRIEF.md
# Serial Converter Power-State Sequencer

This block sits on the host side of a dual-channel serial analog-to-digital converter. It drives the active-low chip-select and the serial clock, and it keeps a record of the converter's power state. The converter selects its power state from the point in a frame where chip-select goes high. A frame that is held through all sixteen clock periods keeps the converter running or wakes it. A frame that is cut short after the fourth falling clock edge sends it into power-down. When a second short frame follows the first, the converter moves from partial power-down into full power-down.

Control logic asks for one of four operations: a conversion, partial power-down, full power-down, or wake. After the supply comes on, a separate start-up pulse runs the dummy-frame chain that brings the converter from an unknown state into the target state. The sequencer enforces a quiet gap after every frame. After a wake it also enforces a settling wait, counted from the falling edge of chip-select, before it reports the converter ready again. Every time in the block is a parameter given in system-clock cycles.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset, cs_n and sclk are 1, busy is 0, ready is 0, and the recorded power state is unknown.
- R2: While cs_n is high, sclk is high. Inside a frame, sclk first stays high for one half period after cs_n falls. It then alternates low and high, and each half period lasts SCLK_HALF cycles.
- R3: A long frame (conversion or wake dummy) contains FRAME_EDGES falling edges of sclk. cs_n rises at the end of the last high half, so the frame lasts (2*FRAME_EDGES+1)*SCLK_HALF cycles.
- R4: A power-down frame contains PD_EDGE falling edges. cs_n rises together with sclk at the end of the low half that follows the last falling edge, so the frame lasts 2*PD_EDGE*SCLK_HALF cycles.
- R5: Between frames of one chain, cs_n stays high for exactly QUIET_CYC cycles. Before any frame it has been high for at least QUIET_CYC cycles.
- R6: When idle, a start-up pulse is accepted in any power state. Its target code selects the chain: 1 gives one long frame then one power-down frame (the result is partial power-down). 2 gives one long frame then two power-down frames (the result is full power-down). 0 or 3 gives one long frame and a WAKE_FULL_CYC wait (the result is normal).
- R7: req_op codes are 0 = convert, 1 = partial power-down, 2 = full power-down, 3 = wake. Convert is legal only in normal and issues one long frame. Code 1 is legal only in normal and issues one power-down frame. Code 2 issues two power-down frames from normal and one from partial. Wake is legal from partial or full and issues one long frame.
- R8: For each accepted operation, busy falls max(sum over frames of (frame length + QUIET_CYC), W) cycles after the first fall of cs_n. W is WAKE_PART_CYC for a wake from partial. W is WAKE_FULL_CYC for a wake from full or a start-up to normal. W is 0 for everything else.
- R9: ready is 1 exactly when the sequencer is idle and the recorded power state is normal.
- R10: The block ignores a request that is illegal in the current state, and it ignores any request or start-up pulse that arrives while busy. An ignored request produces no frame and leaves ready unchanged. When a start-up pulse and a request arrive in the same cycle, the start-up pulse wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startup_go | input | 1 | One-cycle pulse that starts the supply-on chain |
| startup_tgt | input | 2 | Target state for the start-up chain (0/3 normal, 1 partial, 2 full) |
| req_valid | input | 1 | One-cycle request strobe |
| req_op | input | 2 | Requested operation code |
| cs_n | output | 1 | Active-low chip-select to the converter |
| sclk | output | 1 | Serial clock to the converter, idles high |
| busy | output | 1 | A frame, quiet gap or settling wait is in progress |
| ready | output | 1 | Idle with the converter known to be in normal mode |

## Verification
The bench builds the block with SCLK_HALF = 2, QUIET_CYC = 3, WAKE_PART_CYC = 80 and WAKE_FULL_CYC = 300. With these values a long frame plus its quiet gap takes 69 cycles. The partial-wake wait therefore outlasts the frame and its gap, so R8 has to pick the wait rather than the frame. The full-power wait is long enough to be measured, yet a run of dozens of random operations still finishes well inside the cycle limit. Two half-period cycles per clock phase make any off-by-one in the edge counter or the release point visible at the chip-select pin.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

    typedef enum logic [1:0] {
        PW_UNKNOWN = 2'd0,
        PW_NORMAL  = 2'd1,
        PW_PARTIAL = 2'd2,
        PW_FULL    = 2'd3
    } pwr_e;

    typedef enum logic [1:0] {
        OP_CONV = 2'd0,
        OP_PART = 2'd1,
        OP_FULL = 2'd2,
        OP_WAKE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        WT_NONE = 2'd0,
        WT_PART = 2'd1,
        WT_FULL = 2'd2
    } wait_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_QUIET = 2'd2
    } st_e;

    typedef struct packed {
        logic       accept;
        logic       lead;
        logic [1:0] npd;
        wait_e      wsel;
        pwr_e       tgt;
    } plan_t;

endpackage

// File: rtl/adc_seq_plan.sv
module adc_seq_plan
    import adc_pwr_pkg::*;
(
    input  pwr_e       pstate,
    input  logic       startup_go,
    input  logic [1:0] startup_tgt,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    output plan_t      plan
);

    always_comb begin
        plan.accept = 1'b0;
        plan.lead   = 1'b0;
        plan.npd    = 2'd0;
        plan.wsel   = WT_NONE;
        plan.tgt    = pstate;
        if (startup_go) begin
            plan.accept = 1'b1;
            plan.lead   = 1'b1;
            case (startup_tgt)
                2'd1: begin plan.npd = 2'd1; plan.tgt = PW_PARTIAL; end
                2'd2: begin plan.npd = 2'd2; plan.tgt = PW_FULL;    end
                default: begin plan.wsel = WT_FULL; plan.tgt = PW_NORMAL; end
            endcase
        end else if (req_valid) begin
            case (op_e'(req_op))
                OP_CONV: if (pstate == PW_NORMAL) begin
                    plan.accept = 1'b1;
                    plan.lead   = 1'b1;
                    plan.tgt    = PW_NORMAL;
                end
                OP_PART: if (pstate == PW_NORMAL) begin
                    plan.accept = 1'b1;
                    plan.npd    = 2'd1;
                    plan.tgt    = PW_PARTIAL;
                end
                OP_FULL: if (pstate == PW_NORMAL || pstate == PW_PARTIAL) begin
                    plan.accept = 1'b1;
                    plan.npd    = (pstate == PW_NORMAL) ? 2'd2 : 2'd1;
                    plan.tgt    = PW_FULL;
                end
                default: if (pstate == PW_PARTIAL || pstate == PW_FULL) begin
                    plan.accept = 1'b1;
                    plan.lead   = 1'b1;
                    plan.wsel   = (pstate == PW_PARTIAL) ? WT_PART : WT_FULL;
                    plan.tgt    = PW_NORMAL;
                end
            endcase
        end
    end

endmodule

// File: rtl/adc_seq_satcnt.sv
module adc_seq_satcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load1,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load1)
            cnt_d = W'(1);
        else if (inc && cnt_q != '1)
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
    import adc_pwr_pkg::*;
#(
    parameter int SCLK_HALF     = 2,
    parameter int FRAME_EDGES   = 16,
    parameter int PD_EDGE       = 4,
    parameter int QUIET_CYC     = 4,
    parameter int WAKE_PART_CYC = 25,
    parameter int WAKE_FULL_CYC = 750000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       startup_go,
    input  logic [1:0] startup_tgt,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    output logic       cs_n,
    output logic       sclk,
    output logic       busy,
    output logic       ready
);

    localparam int HALF_W = $clog2(2 * FRAME_EDGES + 2);
    localparam int DIV_W  = $clog2(SCLK_HALF + 1);
    localparam int Q_W    = $clog2(QUIET_CYC + 1);
    localparam int T_W    = $clog2(WAKE_FULL_CYC + WAKE_PART_CYC + 2);
    localparam logic [HALF_W-1:0] LAST_LONG = HALF_W'(2 * FRAME_EDGES);
    localparam logic [HALF_W-1:0] LAST_PD   = HALF_W'(2 * PD_EDGE - 1);

    typedef struct packed {
        st_e               st;
        logic              cs_n;
        logic              sclk;
        logic              frame_pd;
        logic [DIV_W-1:0]  div;
        logic [HALF_W-1:0] half;
        logic [1:0]        pd_left;
        wait_e             wsel;
        logic [Q_W-1:0]    qcnt;
        pwr_e              pstate;
        pwr_e              tgt;
    } seq_t;

    seq_t              s_d, s_q;
    plan_t             plan;
    logic [T_W-1:0]    tmr;
    logic [T_W-1:0]    need_cyc;
    logic [HALF_W-1:0] last_half;
    logic [HALF_W-1:0] half_nx;
    logic              take;

    adc_seq_plan u_plan (
        .pstate      (s_q.pstate),
        .startup_go  (startup_go),
        .startup_tgt (startup_tgt),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .plan        (plan)
    );

    assign take = (s_q.st == ST_IDLE) && plan.accept;

    adc_seq_satcnt #(.W(T_W)) u_wake_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load1 (take),
        .inc   (s_q.st != ST_IDLE),
        .cnt   (tmr)
    );

    always_comb begin
        case (s_q.wsel)
            WT_PART: need_cyc = T_W'(WAKE_PART_CYC);
            WT_FULL: need_cyc = T_W'(WAKE_FULL_CYC);
            default: need_cyc = '0;
        endcase
    end

    assign last_half = s_q.frame_pd ? LAST_PD : LAST_LONG;
    assign half_nx   = s_q.half + HALF_W'(1);

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (plan.accept) begin
                    s_d.st       = ST_FRAME;
                    s_d.cs_n     = 1'b0;
                    s_d.sclk     = 1'b1;
                    s_d.div      = '0;
                    s_d.half     = '0;
                    s_d.frame_pd = !plan.lead;
                    s_d.pd_left  = plan.lead ? plan.npd : 2'(plan.npd - 2'd1);
                    s_d.wsel     = plan.wsel;
                    s_d.tgt      = plan.tgt;
                end
            end
            ST_FRAME: begin
                if (s_q.div == DIV_W'(SCLK_HALF - 1)) begin
                    s_d.div = '0;
                    if (s_q.half == last_half) begin
                        s_d.cs_n = 1'b1;
                        s_d.sclk = 1'b1;
                        s_d.st   = ST_QUIET;
                        s_d.qcnt = '0;
                    end else begin
                        s_d.half = half_nx;
                        s_d.sclk = ~half_nx[0];
                    end
                end else begin
                    s_d.div = s_q.div + DIV_W'(1);
                end
            end
            ST_QUIET: begin
                if (s_q.qcnt != Q_W'(QUIET_CYC - 1)) begin
                    s_d.qcnt = s_q.qcnt + Q_W'(1);
                end else if (s_q.pd_left != 2'd0) begin
                    s_d.st       = ST_FRAME;
                    s_d.cs_n     = 1'b0;
                    s_d.sclk     = 1'b1;
                    s_d.div      = '0;
                    s_d.half     = '0;
                    s_d.frame_pd = 1'b1;
                    s_d.pd_left  = s_q.pd_left - 2'd1;
                end else if (tmr >= need_cyc) begin
                    s_d.st     = ST_IDLE;
                    s_d.pstate = s_q.tgt;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.st       <= ST_IDLE;
            s_q.cs_n     <= 1'b1;
            s_q.sclk     <= 1'b1;
            s_q.wsel     <= WT_NONE;
            s_q.pstate   <= PW_UNKNOWN;
            s_q.tgt      <= PW_UNKNOWN;
        end else begin
            s_q <= s_d;
        end
    end

    assign cs_n  = s_q.cs_n;
    assign sclk  = s_q.sclk;
    assign busy  = (s_q.st != ST_IDLE);
    assign ready = (s_q.st == ST_IDLE) && (s_q.pstate == PW_NORMAL);

    // Observation counters for the frame-shape and quiet-gap properties
    logic              chk_sclk_p;
    logic [HALF_W-1:0] chk_falls;
    logic [Q_W-1:0]    chk_hi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_sclk_p <= 1'b1;
            chk_falls  <= '0;
            chk_hi     <= Q_W'(QUIET_CYC);
        end else begin
            chk_sclk_p <= sclk;
            if (cs_n)
                chk_falls <= '0;
            else if (chk_sclk_p && !sclk)
                chk_falls <= chk_falls + HALF_W'(1);
            if (!cs_n)
                chk_hi <= '0;
            else if (chk_hi < Q_W'(QUIET_CYC))
                chk_hi <= chk_hi + Q_W'(1);
        end
    end

    a_r2_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    // R3 and R4: a frame ends after exactly the long or the power-down edge count
    a_r4_frame_edge_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (chk_falls == HALF_W'(FRAME_EDGES) || chk_falls == HALF_W'(PD_EDGE)));

    a_r5_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (chk_hi >= Q_W'(QUIET_CYC)));

    a_r9_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !busy);

    a_r10_idle_keeps_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    a_r10_busy_ignores_plan: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && $past(cs_n) && !cs_n) |-> ($past(s_q.pd_left) != 2'd0));

endmodule

// File: tb/adc_pwr_seq_bench.sv
module adc_pwr_seq_bench;

    localparam int DIV = 2;
    localparam int FE  = 16;
    localparam int PDE = 4;
    localparam int Q   = 3;
    localparam int WP  = 80;
    localparam int WF  = 300;
    localparam int L_LONG = (2 * FE + 1) * DIV;
    localparam int L_PD   = 2 * PDE * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       startup_go = 1'b0;
    logic [1:0] startup_tgt = 2'd0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic       cs_n, sclk, busy, ready;

    int n_vec = 0;
    int n_bad = 0;
    int mdl_ps = 0;   // 0 unknown, 1 normal, 2 partial, 3 full
    bit finished = 1'b0;

    always #4 clk = ~clk;

    adc_pwr_seq #(
        .SCLK_HALF(DIV), .FRAME_EDGES(FE), .PD_EDGE(PDE),
        .QUIET_CYC(Q), .WAKE_PART_CYC(WP), .WAKE_FULL_CYC(WF)
    ) u_adc_pwr_seq (
        .clk(clk), .rst_n(rst_n), .startup_go(startup_go), .startup_tgt(startup_tgt),
        .req_valid(req_valid), .req_op(req_op),
        .cs_n(cs_n), .sclk(sclk), .busy(busy), .ready(ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void model(input int ps, input bit su, input int code,
                                  output bit ok, output int lead, output int npd,
                                  output int need, output int nxt);
        ok = 1'b0; lead = 0; npd = 0; need = 0; nxt = ps;
        if (su) begin
            ok = 1'b1; lead = 1;
            case (code)
                1: begin npd = 1; nxt = 2; end
                2: begin npd = 2; nxt = 3; end
                default: begin need = WF; nxt = 1; end
            endcase
        end else begin
            case (code)
                0: if (ps == 1) begin ok = 1'b1; lead = 1; nxt = 1; end
                1: if (ps == 1) begin ok = 1'b1; npd = 1; nxt = 2; end
                2: if (ps == 1 || ps == 2) begin ok = 1'b1; npd = (ps == 1) ? 2 : 1; nxt = 3; end
                default: if (ps == 2 || ps == 3) begin
                    ok = 1'b1; lead = 1; need = (ps == 2) ? WP : WF; nxt = 1;
                end
            endcase
        end
    endfunction

    task automatic run(input bit su, input int code, input bit also_req, input int req_code);
        bit ok; int lead, npd, need, nxt, t_exp, sum;
        int nfr, cur, hicnt, idle_bad, t_obs;
        int falls[4];
        bit prev_cs, prev_sclk;
        model(mdl_ps, su, code, ok, lead, npd, need, nxt);
        @(negedge clk);
        if (su) begin startup_go = 1'b1; startup_tgt = 2'(code); end
        if (!su || also_req) begin req_valid = 1'b1; req_op = 2'(su ? req_code : code); end
        @(negedge clk);
        startup_go = 1'b0; req_valid = 1'b0;
        if (!ok) begin
            // R10: illegal request must leave pins and ready untouched
            for (int i = 0; i < 4; i++) begin
                chk(!busy && cs_n, "R10 ignored request raised activity", busy, 0);
                chk(ready == (mdl_ps == 1), "R10 ready changed on ignored request", ready, mdl_ps == 1);
                @(negedge clk);
            end
            return;
        end
        nfr = 0; cur = 0; hicnt = 0; idle_bad = 0; t_obs = -1;
        prev_cs = 1'b1; prev_sclk = 1'b1;
        for (int k = 0; k < 4; k++) falls[k] = -1;
        for (int idx = 0; idx < 2000; idx++) begin
            if (idx == 10) begin req_valid = 1'b1; req_op = 2'($urandom_range(0, 3)); startup_go = 1'b1; end
            if (idx == 11) begin req_valid = 1'b0; startup_go = 1'b0; end
            if (!cs_n && prev_cs) begin
                if (nfr > 0) chk(hicnt == Q, "R5 gap between chained frames", hicnt, Q);
                nfr++; cur = 0;
            end
            if (!cs_n && prev_sclk && !sclk) cur++;
            if (cs_n && !prev_cs) begin
                if (nfr >= 1 && nfr <= 4) falls[nfr-1] = cur;
                hicnt = 0;
            end
            if (cs_n) begin hicnt++; if (!sclk) idle_bad++; end
            prev_cs = cs_n; prev_sclk = sclk;
            if (!busy) begin t_obs = idx; break; end
            @(negedge clk);
        end
        chk(nfr == lead + npd, "R6/R7 frame count", nfr, lead + npd);
        sum = 0;
        for (int f = 0; f < lead + npd && f < 4; f++) begin
            if (f == 0 && lead == 1) begin
                chk(falls[f] == FE, "R3 long frame falling edges", falls[f], FE);
                sum += L_LONG + Q;
            end else begin
                chk(falls[f] == PDE, "R4 power-down frame falling edges", falls[f], PDE);
                sum += L_PD + Q;
            end
        end
        t_exp = (need > sum) ? need : sum;
        chk(t_obs == t_exp, "R8 cycles from cs fall to idle", t_obs, t_exp);
        chk(idle_bad == 0, "R2 sclk low while cs high", idle_bad, 0);
        mdl_ps = nxt;
        chk(ready == (mdl_ps == 1), "R9 ready after operation", ready, mdl_ps == 1);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n after reset", cs_n, 1);
        chk(sclk == 1'b1, "R1 sclk after reset", sclk, 1);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(ready == 1'b0, "R1 ready after reset", ready, 0);
        run(1'b0, 0, 1'b0, 0);   // R10 convert while unknown
        run(1'b0, 3, 1'b0, 0);   // R10 wake while unknown
        run(1'b1, 0, 1'b0, 0);   // R6 start-up to normal
        run(1'b0, 0, 1'b0, 0);   // R7 convert
        run(1'b0, 1, 1'b0, 0);   // R7 partial
        run(1'b0, 0, 1'b0, 0);   // R10 convert in partial
        run(1'b0, 1, 1'b0, 0);   // R10 partial in partial
        run(1'b0, 2, 1'b0, 0);   // R7 full from partial
        run(1'b0, 3, 1'b0, 0);   // R8 wake from full
        run(1'b0, 2, 1'b0, 0);   // R7 full from normal
        run(1'b0, 1, 1'b0, 0);   // R10 partial in full
        run(1'b1, 1, 1'b0, 0);   // R6 start-up to partial
        run(1'b0, 3, 1'b0, 0);   // R8 wake from partial
        run(1'b1, 2, 1'b1, 0);   // R10 start-up wins over same-cycle request
        run(1'b1, 3, 1'b0, 0);   // R6 code 3 behaves as normal
        for (int n = 0; n < 40; n++) begin
            bit su;
            su = ($urandom_range(0, 7) == 0);
            run(su, int'($urandom_range(0, 3)), 1'b0, 0);
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule